// File: doc/BRIEF.md
# CAN Receive Object Allocator

This block sits between the frame receiver of a CAN controller and its bank of message objects. Each object holds an acceptance filter (identifier, mask, use-mask switch, extended flag), a direction bit, a valid bit and an end-of-buffer bit. It also holds the stored frame and three flags: new-data, interrupt-pending and message-lost. When the receiver presents an accepted frame for one cycle, the block scans the receive objects upward from object 0. It writes the frame into the first object that is eligible to take it, and sets that object's flags.

Objects whose end-of-buffer bit is clear and whose new-data flag is set are still unread, so the scan passes over them. An object with end-of-buffer set closes a FIFO chain. If the scan reaches it while it is still full, it takes the frame anyway, and its message-lost flag records that unread data was overwritten. When software clears new-data on an object, that object becomes free again. Pending receptions are visible as one new-data bit per object.

Configuration, flag clearing and readback of a stored object use simple one-cycle strobes and a combinational read index.

Top module: `can_rx_alloc`

## Requirements
- R1: A frame presented with `rx_valid` is written into the lowest-numbered candidate object. Its identifier, format flag, remote flag, length and payload are then readable through the `rd_*` ports. The `res_*` outputs report hit, object number and overwrite one cycle after `rx_valid`.
- R2: Storing a frame sets the object's new-data and interrupt-pending flags. `irq` is high while any object has interrupt-pending set.
- R3: An object with new-data set and end-of-buffer clear is skipped, and its contents stay unchanged. An object with new-data set and end-of-buffer set is overwritten, and its message-lost flag becomes set and stays set until cleared.
- R4: With use-mask clear, all 29 identifier bits and the extended flag must equal the object's. With use-mask set, only identifier bits whose mask bit is 1 are compared and the extended flag is ignored, so a zero mask accepts every frame.
- R5: An object with valid clear, or with direction set to transmit, never receives a frame, even if its filter matches.
- R6: `newdat_map[i]` is the new-data flag of object i (bit 0 is object 0).
- R7: A clear strobe with `clr_newdat` frees that object. The next matching frame goes to the lowest free object again.
- R8: If no object is a candidate, the frame is dropped: `res_hit` is 0 and no flag or stored frame changes.
- R9: After reset every object is invalid, all flags are zero, `irq` is 0 and `res_valid` is 0.
- R10: A configuration write to an object clears its new-data, interrupt-pending and message-lost flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_obj | input | 4 | Object index for the configuration write |
| cfg_valid | input | 1 | Object takes part in operation |
| cfg_xmit | input | 1 | Direction: 1 = transmit object |
| cfg_use_mask | input | 1 | Apply acceptance mask |
| cfg_eob | input | 1 | End-of-buffer (closes a FIFO chain) |
| cfg_xtd | input | 1 | Extended-format identifier expected |
| cfg_id | input | 29 | Filter identifier |
| cfg_mask | input | 29 | Filter mask, 1 = compare bit |
| clr_wr | input | 1 | Flag clear strobe |
| clr_obj | input | 4 | Object index for the flag clear |
| clr_newdat | input | 1 | Clear new-data |
| clr_intpnd | input | 1 | Clear interrupt-pending |
| clr_lost | input | 1 | Clear message-lost |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 29 | Frame identifier |
| rx_xtd | input | 1 | Frame uses extended format |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | 64 | Frame payload |
| rd_obj | input | 4 | Readback object index |
| rd_id | output | 29 | Stored identifier |
| rd_xtd | output | 1 | Stored format flag |
| rd_rtr | output | 1 | Stored remote flag |
| rd_dlc | output | 4 | Stored length code |
| rd_data | output | 64 | Stored payload |
| rd_lost | output | 1 | Message-lost flag of the object |
| newdat_map | output | 16 | New-data flag per object |
| irq | output | 1 | Any interrupt-pending set |
| res_valid | output | 1 | Result of previous cycle's frame |
| res_hit | output | 1 | Frame was stored |
| res_obj | output | 4 | Object that took the frame |
| res_lost | output | 1 | Store overwrote unread data |

## Verification
The bench targets four failure modes. First, a full object in the middle of the chain: a scan that does not skip it would destroy unread data, and one that stops there would drop a frame a higher object could take. Second, the full end-of-buffer object: a design that skips it would drop the frame silently, and one that forgets message-lost would hide the overwrite. Third, filter edges: a frame with the right number but the wrong format, a partial mask, and matching objects that are invalid or set to transmit; a loose filter stores into the wrong object. Fourth, freeing two objects out of order: the next frames must go to the lower one first, and a design that refills in clear order or keeps a fill pointer would pick the wrong object.

// File: rtl/can_rxa_pkg.sv
package can_rxa_pkg;

  localparam int unsigned ID_W   = 29;
  localparam int unsigned DLC_W  = 4;
  localparam int unsigned DATA_W = 64;

  // Filter and mode settings of one message object
  typedef struct packed {
    logic              valid;
    logic              xmit;
    logic              use_mask;
    logic              eob;
    logic              xtd;
    logic [ID_W-1:0]   id;
    logic [ID_W-1:0]   mask;
  } obj_cfg_t;

  // Stored frame contents
  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              xtd;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Acceptance test: exact match unless use_mask, then only masked bits
  function automatic logic id_accept(obj_cfg_t c, logic [ID_W-1:0] fid, logic fxtd);
    logic [ID_W-1:0] cmp;
    cmp = c.use_mask ? c.mask : {ID_W{1'b1}};
    if (!c.use_mask && (fxtd != c.xtd)) return 1'b0;
    return ((fid ^ c.id) & cmp) == '0;
  endfunction

  // An eligible object is a candidate when free or when it closes a chain
  function automatic logic takes_frame(logic eligible, logic full, logic eob);
    return eligible && (!full || eob);
  endfunction

endpackage

// File: rtl/can_rxa_filter.sv
module can_rxa_filter
  import can_rxa_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 16
) (
  input  obj_cfg_t [NUM_OBJ-1:0] cfg_vec,
  input  logic [NUM_OBJ-1:0]     full_vec,
  input  logic [ID_W-1:0]        fr_id,
  input  logic                   fr_xtd,
  output logic [NUM_OBJ-1:0]     elig_vec,
  output logic [NUM_OBJ-1:0]     cand_vec
);

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic rx_obj;
    assign rx_obj      = cfg_vec[g].valid && !cfg_vec[g].xmit;
    assign elig_vec[g] = rx_obj && id_accept(cfg_vec[g], fr_id, fr_xtd);
    assign cand_vec[g] = takes_frame(elig_vec[g], full_vec[g], cfg_vec[g].eob);
  end

endmodule

// File: rtl/can_rxa_pick.sv
module can_rxa_pick #(
  parameter int unsigned NUM_OBJ = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic [NUM_OBJ-1:0] cand_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);

  // Descending walk: the last assignment is the lowest set bit
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = NUM_OBJ - 1; k >= 0; k--) begin
      if (cand_vec[k]) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/can_rxa_objstore.sv
module can_rxa_objstore
  import can_rxa_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  obj_cfg_t               cfg_in,
  input  logic                   clr_we,
  input  logic [IDX_W-1:0]       clr_idx,
  input  logic                   clr_nd,
  input  logic                   clr_ip,
  input  logic                   clr_ml,
  input  logic                   st_we,
  input  logic [IDX_W-1:0]       st_idx,
  input  frame_t                 st_frame,
  output obj_cfg_t [NUM_OBJ-1:0] cfg_vec,
  output frame_t   [NUM_OBJ-1:0] frm_vec,
  output logic [NUM_OBJ-1:0]     nd_vec,
  output logic [NUM_OBJ-1:0]     ip_vec,
  output logic [NUM_OBJ-1:0]     ml_vec
);

  logic [NUM_OBJ-1:0] wr_sel;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic cfg_here, clr_here;
    assign cfg_here  = cfg_we && (cfg_idx == IDX_W'(g));
    assign clr_here  = clr_we && (clr_idx == IDX_W'(g));
    assign wr_sel[g] = st_we && (st_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_vec[g] <= '0;
        frm_vec[g] <= '0;
        nd_vec[g]  <= 1'b0;
        ip_vec[g]  <= 1'b0;
        ml_vec[g]  <= 1'b0;
      end else begin
        if (cfg_here) begin
          cfg_vec[g] <= cfg_in;
          nd_vec[g]  <= 1'b0;
          ip_vec[g]  <= 1'b0;
          ml_vec[g]  <= 1'b0;
        end else if (clr_here) begin
          if (clr_nd) nd_vec[g] <= 1'b0;
          if (clr_ip) ip_vec[g] <= 1'b0;
          if (clr_ml) ml_vec[g] <= 1'b0;
        end
        // a store wins over a clear or reconfigure of the same object
        if (wr_sel[g]) begin
          frm_vec[g] <= st_frame;
          nd_vec[g]  <= 1'b1;
          ip_vec[g]  <= 1'b1;
          if (nd_vec[g]) ml_vec[g] <= 1'b1;
        end
      end
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R1

  AST_OVERWRITE_EOB: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && nd_vec[st_idx]) |-> cfg_vec[st_idx].eob); // R3

endmodule

// File: rtl/can_rx_alloc.sv
module can_rx_alloc
  import can_rxa_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_obj,
  input  logic              cfg_valid,
  input  logic              cfg_xmit,
  input  logic              cfg_use_mask,
  input  logic              cfg_eob,
  input  logic              cfg_xtd,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ID_W-1:0]   cfg_mask,
  input  logic              clr_wr,
  input  logic [IDX_W-1:0]  clr_obj,
  input  logic              clr_newdat,
  input  logic              clr_intpnd,
  input  logic              clr_lost,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_xtd,
  input  logic              rx_rtr,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [IDX_W-1:0]  rd_obj,
  output logic [ID_W-1:0]   rd_id,
  output logic              rd_xtd,
  output logic              rd_rtr,
  output logic [DLC_W-1:0]  rd_dlc,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_lost,
  output logic [NUM_OBJ-1:0] newdat_map,
  output logic              irq,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_obj,
  output logic              res_lost
);

  obj_cfg_t [NUM_OBJ-1:0] cfg_vec;
  frame_t   [NUM_OBJ-1:0] frm_vec;
  logic [NUM_OBJ-1:0] nd_vec, ip_vec, ml_vec;
  logic [NUM_OBJ-1:0] elig_vec, cand_vec;
  logic               pick_hit;
  logic [IDX_W-1:0]   pick_idx;
  logic               st_we;
  obj_cfg_t           cfg_in;
  frame_t             rx_frame;
  logic [NUM_OBJ-1:0] below_mask;

  assign cfg_in = '{valid: cfg_valid, xmit: cfg_xmit, use_mask: cfg_use_mask,
                    eob: cfg_eob, xtd: cfg_xtd, id: cfg_id, mask: cfg_mask};
  assign rx_frame = '{id: rx_id, xtd: rx_xtd, rtr: rx_rtr, dlc: rx_dlc, data: rx_data};

  can_rxa_filter #(.NUM_OBJ(NUM_OBJ)) filter_i (
    .cfg_vec (cfg_vec),
    .full_vec(nd_vec),
    .fr_id   (rx_id),
    .fr_xtd  (rx_xtd),
    .elig_vec(elig_vec),
    .cand_vec(cand_vec)
  );

  can_rxa_pick #(.NUM_OBJ(NUM_OBJ)) pick_i (
    .cand_vec(cand_vec),
    .hit     (pick_hit),
    .idx     (pick_idx)
  );

  assign st_we = rx_valid && pick_hit;

  can_rxa_objstore #(.NUM_OBJ(NUM_OBJ)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_wr),
    .cfg_idx (cfg_obj),
    .cfg_in  (cfg_in),
    .clr_we  (clr_wr),
    .clr_idx (clr_obj),
    .clr_nd  (clr_newdat),
    .clr_ip  (clr_intpnd),
    .clr_ml  (clr_lost),
    .st_we   (st_we),
    .st_idx  (pick_idx),
    .st_frame(rx_frame),
    .cfg_vec (cfg_vec),
    .frm_vec (frm_vec),
    .nd_vec  (nd_vec),
    .ip_vec  (ip_vec),
    .ml_vec  (ml_vec)
  );

  // one-cycle result record of each presented frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_obj   <= '0;
      res_lost  <= 1'b0;
    end else begin
      res_valid <= rx_valid;
      res_hit   <= st_we;
      res_obj   <= pick_idx;
      res_lost  <= st_we && nd_vec[pick_idx];
    end
  end

  assign newdat_map = nd_vec;
  assign irq        = |ip_vec;
  assign rd_id      = frm_vec[rd_obj].id;
  assign rd_xtd     = frm_vec[rd_obj].xtd;
  assign rd_rtr     = frm_vec[rd_obj].rtr;
  assign rd_dlc     = frm_vec[rd_obj].dlc;
  assign rd_data    = frm_vec[rd_obj].data;
  assign rd_lost    = ml_vec[rd_obj];

  assign below_mask = (NUM_OBJ'(1) << pick_idx) - NUM_OBJ'(1);

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (cand_vec & below_mask) == '0); // R1

  AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> newdat_map[$past(pick_idx)] && irq); // R2

  AST_LOST_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_lost) |-> ml_vec[res_obj]); // R3

  AST_NO_TX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (cfg_vec[pick_idx].valid && !cfg_vec[pick_idx].xmit)); // R5

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pick_hit && !clr_wr && !cfg_wr) |=> $stable(newdat_map)); // R8

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !st_we) |=> !newdat_map[$past(cfg_obj)]); // R10

endmodule

// File: tb/can_rx_alloc_tb.sv
`timescale 1ns/1ps
module can_rx_alloc_tb_top;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_valid = 0, cfg_xmit = 0, cfg_use_mask = 0, cfg_eob = 0, cfg_xtd = 0;
  logic [3:0] cfg_obj = 0;
  logic [28:0] cfg_id = 0, cfg_mask = 0;
  logic clr_wr = 0, clr_newdat = 0, clr_intpnd = 0, clr_lost = 0;
  logic [3:0] clr_obj = 0;
  logic rx_valid = 0, rx_xtd = 0, rx_rtr = 0;
  logic [28:0] rx_id = 0;
  logic [3:0] rx_dlc = 0;
  logic [63:0] rx_data = 0;
  logic [3:0] rd_obj = 0;
  logic [28:0] rd_id;
  logic rd_xtd, rd_rtr, rd_lost;
  logic [3:0] rd_dlc;
  logic [63:0] rd_data;
  logic [N-1:0] newdat_map;
  logic irq, res_valid, res_hit, res_lost;
  logic [3:0] res_obj;

  always #2 clk = ~clk;

  can_rx_alloc dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_obj(cfg_obj), .cfg_valid(cfg_valid), .cfg_xmit(cfg_xmit),
    .cfg_use_mask(cfg_use_mask), .cfg_eob(cfg_eob), .cfg_xtd(cfg_xtd),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask),
    .clr_wr(clr_wr), .clr_obj(clr_obj), .clr_newdat(clr_newdat),
    .clr_intpnd(clr_intpnd), .clr_lost(clr_lost),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_xtd(rx_xtd), .rx_rtr(rx_rtr),
    .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rd_obj(rd_obj), .rd_id(rd_id), .rd_xtd(rd_xtd), .rd_rtr(rd_rtr),
    .rd_dlc(rd_dlc), .rd_data(rd_data), .rd_lost(rd_lost),
    .newdat_map(newdat_map), .irq(irq),
    .res_valid(res_valid), .res_hit(res_hit), .res_obj(res_obj), .res_lost(res_lost)
  );

  typedef struct {
    bit       hit;
    int       obj;
    bit       lost;
    string    req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side object model
  bit         m_valid[N], m_xmit[N], m_um[N], m_eob[N], m_xtd[N], m_nd[N];
  bit [28:0]  m_id[N], m_mask[N];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit accepts(int i, bit [28:0] fid, bit fxtd);
    if (m_um[i]) return (fid & m_mask[i]) == (m_id[i] & m_mask[i]);
    return (fid == m_id[i]) && (fxtd == m_xtd[i]);
  endfunction

  task automatic set_obj(int i, bit v, bit x, bit um, bit eob, bit xtd, bit [28:0] id, bit [28:0] mask);
    cfg_wr = 1; cfg_obj = 4'(i); cfg_valid = v; cfg_xmit = x; cfg_use_mask = um;
    cfg_eob = eob; cfg_xtd = xtd; cfg_id = id; cfg_mask = mask;
    @(negedge clk);
    cfg_wr = 0;
    m_valid[i] = v; m_xmit[i] = x; m_um[i] = um; m_eob[i] = eob;
    m_xtd[i] = xtd; m_id[i] = id; m_mask[i] = mask; m_nd[i] = 0;
  endtask

  task automatic release_obj(int i);
    clr_wr = 1; clr_obj = 4'(i); clr_newdat = 1; clr_intpnd = 1; clr_lost = 0;
    @(negedge clk);
    clr_wr = 0; clr_newdat = 0; clr_intpnd = 0;
    m_nd[i] = 0;
  endtask

  // driver: predicts the target object and pushes it to the scoreboard
  task automatic send(string req, bit [28:0] id, bit xtd, bit rtr, bit [3:0] dlc, bit [63:0] data);
    exp_t e;
    e.hit = 0; e.obj = 0; e.lost = 0; e.req = req;
    for (int i = 0; i < N; i++) begin
      if (!e.hit && m_valid[i] && !m_xmit[i] && accepts(i, id, xtd) && (!m_nd[i] || m_eob[i])) begin
        e.hit = 1; e.obj = i; e.lost = m_nd[i];
      end
    end
    if (e.hit) m_nd[e.obj] = 1;
    exp_q.push_back(e);
    rx_valid = 1; rx_id = id; rx_xtd = xtd; rx_rtr = rtr; rx_dlc = dlc; rx_data = data;
    @(negedge clk);
    rx_valid = 0;
  endtask

  // monitor: pops one prediction per reported result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected result", 64'(res_valid), 64'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " hit"}, 64'(res_hit), 64'(e.hit));
        if (e.hit) begin
          check({e.req, " obj"}, 64'(res_obj), 64'(e.obj));
          check({e.req, " lost"}, 64'(res_lost), 64'(e.lost));
        end
      end
    end
  end

  task automatic readback(string req, int i, bit [28:0] id, bit xtd, bit rtr, bit [3:0] dlc, bit [63:0] data, bit lost);
    rd_obj = 4'(i);
    #1;
    check({req, " rd_id"}, 64'(rd_id), 64'(id));
    check({req, " rd_xtd"}, 64'(rd_xtd), 64'(xtd));
    check({req, " rd_rtr"}, 64'(rd_rtr), 64'(rtr));
    check({req, " rd_dlc"}, 64'(rd_dlc), 64'(dlc));
    check({req, " rd_data"}, rd_data, data);
    check({req, " rd_lost"}, 64'(rd_lost), 64'(lost));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_xmit[i] = 0; m_um[i] = 0; m_eob[i] = 0;
      m_xtd[i] = 0; m_nd[i] = 0; m_id[i] = 0; m_mask[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9 newdat_map", 64'(newdat_map), 64'(0));
    check("R9 irq", 64'(irq), 64'(0));
    check("R9 res_valid", 64'(res_valid), 64'(0));

    // filter phase
    set_obj(3, 0, 0, 1, 0, 0, 29'h0, 29'h0);            // invalid, accepts all
    set_obj(8, 1, 1, 1, 0, 0, 29'h0, 29'h0);            // transmit, accepts all
    set_obj(9, 1, 0, 0, 0, 0, 29'h123, 29'h0);          // exact standard 0x123
    set_obj(10, 1, 0, 1, 0, 1, 29'h1ABC0000, 29'h1FFF0000);

    send("R5 invalid/transmit ignored", 29'h555, 0, 0, 4'd2, 64'hAA55);
    check("R8 map after drop", 64'(newdat_map), 64'(0));
    check("R8 irq after drop", 64'(irq), 64'(0));

    send("R1 exact store", 29'h123, 0, 0, 4'd8, 64'h0102030405060708);
    readback("R1", 9, 29'h123, 0, 0, 4'd8, 64'h0102030405060708, 0);
    check("R6 map obj9", 64'(newdat_map), 64'(16'h0200));
    check("R2 irq", 64'(irq), 64'(1));

    send("R4 format mismatch", 29'h123, 1, 0, 4'd1, 64'h11);
    send("R4 masked extended", 29'h1ABC1234, 1, 1, 4'd0, 64'h0);
    readback("R4", 10, 29'h1ABC1234, 1, 1, 4'd0, 64'h0, 0);
    check("R6 map obj9/10", 64'(newdat_map), 64'(16'h0600));
    send("R4 masked miss", 29'h124, 0, 0, 4'd1, 64'h22);

    send("R3 full non-eob skipped", 29'h123, 0, 0, 4'd3, 64'hDEAD);
    readback("R3 unchanged", 9, 29'h123, 0, 0, 4'd8, 64'h0102030405060708, 0);

    release_obj(9);
    check("R7 map after clear", 64'(newdat_map), 64'(16'h0400));
    send("R7 refill", 29'h123, 0, 0, 4'd2, 64'hBEEF);
    readback("R7", 9, 29'h123, 0, 0, 4'd2, 64'hBEEF, 0);

    // reconfiguration clears flags
    set_obj(9, 0, 0, 0, 0, 0, 29'h0, 29'h0);
    set_obj(10, 0, 0, 0, 0, 0, 29'h0, 29'h0);
    check("R10 map after cfg", 64'(newdat_map), 64'(0));
    check("R10 irq after cfg", 64'(irq), 64'(0));

    // FIFO phase: objects 0..7 accept all, 7 closes the chain
    for (int i = 0; i < 8; i++) set_obj(i, 1, 0, 1, (i == 7), 0, 29'h0, 29'h0);
    for (int i = 0; i < 8; i++)
      send("R1 fifo fill", 29'(i + 16), (i == 4), (i == 6), 4'(i), 64'(i) * 64'h1111);
    check("R6 map fifo full", 64'(newdat_map), 64'(16'h00FF));
    readback("R1 fifo obj4", 4, 29'd20, 1, 0, 4'd4, 64'h4444, 0);

    send("R3 eob overwrite", 29'h7FF, 0, 0, 4'd8, 64'hCAFEF00D);
    readback("R3 eob", 7, 29'h7FF, 0, 0, 4'd8, 64'hCAFEF00D, 1);
    readback("R3 neighbour", 6, 29'd22, 0, 1, 4'd6, 64'h6666, 0);

    release_obj(5);
    release_obj(2);
    check("R7 map two freed", 64'(newdat_map), 64'(16'h00DB));
    send("R7 lowest free first", 29'h40, 0, 0, 4'd1, 64'h77);
    send("R7 next free", 29'h41, 0, 0, 4'd1, 64'h88);
    readback("R7 obj2", 2, 29'h40, 0, 0, 4'd1, 64'h77, 0);
    readback("R7 obj5", 5, 29'h41, 0, 0, 4'd1, 64'h88, 0);
    send("R3 eob again", 29'h42, 0, 0, 4'd1, 64'h99);
    check("R6 map end", 64'(newdat_map), 64'(16'h00FF));

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", 64'(exp_q.size()), 64'(0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule